// File: doc/BRIEF.md
# Interrupt and Reset Entry Sequencer

This block takes an 8-bit accumulator CPU into its service routines. It watches three hardware requests and one software request: a reset request, a non-maskable request arriving as a falling edge, a maskable level request, and the break instruction signalled by the core. It acts only when the core strobes an instruction boundary. At that point it picks one winner by fixed priority and runs a short entry sequence on a memory port with single-cycle reads.

For the maskable request, the non-maskable request and the break instruction, the sequence has five steps. It pushes the return address high byte, then the low byte, then the status byte into the stack in page one. It then reads a two-byte vector, low byte first, and loads it into the program counter. A reset skips the three pushes. It reads its own vector, tells the core to set the interrupt-disable flag, and reloads the program counter.

The core supplies the program counter, the stack pointer and the status byte. The block returns a stack pointer update for each push, a strobe to set the interrupt-disable flag, and a program counter load. The core should stall its own sequencing while `busy` is high.

Top module: `irq_entry_seq`

## Requirements
- R1: A request starts an entry sequence only if the block is idle and `boundary` is high on that clock edge. Requests seen without `boundary` start nothing, and `boundary` is ignored while busy.
- R2: When several requests are eligible at the same boundary, the winner follows a fixed order: reset, then the non-maskable request, then the maskable request, then the break request.
- R3: A reset entry lasts two cycles and writes no memory. In the first cycle it reads address 0xFFFC and raises `i_set`. In the second it reads 0xFFFD and loads PC with {data at 0xFFFD, data at 0xFFFC}.
- R4: The maskable request is taken only if status bit 2 (interrupt disable) is 0 at the boundary. A request seen while that bit is 1 is dropped and leaves nothing pending.
- R5: The three pushes write in a fixed order to 0x0100 + SP: return high byte, then return low byte, then status. SP decrements by one after each push and wraps within 8 bits. `sp_we` with `sp_out` reports the new SP on each push.
- R6: The pushed status byte equals the sampled status with bit 4 forced to 0 for hardware interrupts and to 1 for a break. `i_set` is high in the status-push cycle.
- R7: After the pushes, the vector low byte is read in one cycle and the high byte in the next, where `pc_we` loads PC = {high, low}. The non-maskable vector sits at 0xFFFA/0xFFFB. The maskable and break vector sits at 0xFFFE/0xFFFF.
- R8: One falling edge on `nmi_n` produces exactly one service. Holding the pin low produces no further service. An edge that arrives during another entry is served at a later boundary.
- R9: A pending reset or non-maskable request stays pending until its own entry sequence completes, and is then cleared, so each is served exactly once.
- R10: After `rst_n` is released, a reset entry is pending and runs at the first boundary.
- R11: `busy` is high exactly during an entry sequence: five cycles for an interrupt or break, two for a reset. Memory writes, `i_set` and `pc_we` occur only while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| boundary | input | 1 | Core is between instructions |
| rst_req | input | 1 | CPU reset request, rising edge latched |
| nmi_n | input | 1 | Non-maskable request, falling edge latched |
| irq_req | input | 1 | Maskable request level |
| brk_req | input | 1 | Break instruction decoded by the core |
| pc_in | input | 16 | Return address from the core |
| sp_in | input | 8 | Stack pointer from the core |
| p_in | input | 8 | Status byte from the core |
| mem_addr | output | 16 | Memory address |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid in the same cycle |
| sp_we | output | 1 | Stack pointer update strobe |
| sp_out | output | 8 | New stack pointer value |
| i_set | output | 1 | Set the interrupt-disable flag |
| pc_we | output | 1 | Program counter load strobe |
| pc_out | output | 16 | New program counter value |
| busy | output | 1 | Entry sequence in progress |

## Verification
The checker watches these properties on every cycle:
- a sequence starts only after a boundary;
- every write lands in page one;
- consecutive push updates step the stack pointer down by one;
- side effects appear only while busy;
- the program counter load comes from an odd vector address and is the last cycle of a sequence.

The full byte order, the pushed values, the vector choice, the priority, the dropping of a masked request and the exactly-once service of latched requests depend on the history of the requests. Only the bench scenarios can show these, by comparing every cycle against a queue of expected bus activity.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PSH_HI,
    ST_PSH_LO,
    ST_PSH_ST,
    ST_VEC_LO,
    ST_VEC_HI
  } seq_state_e;

  typedef enum logic [1:0] {
    SRC_RST,
    SRC_NMI,
    SRC_IRQ,
    SRC_BRK
  } src_e;
endpackage

// File: rtl/irq_seq_pending.sv
module irq_seq_pending
  import irq_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rst_req,
  input  logic nmi_n,
  input  logic done,
  input  src_e done_src,
  output logic rst_pend,
  output logic nmi_pend
);
  logic rst_d, nmi_d;
  logic rst_pend_nxt, nmi_pend_nxt;
  logic rst_rise, nmi_fall;

  assign rst_rise = rst_req & ~rst_d;
  assign nmi_fall = nmi_d & ~nmi_n;

  always_comb begin
    rst_pend_nxt = rst_rise | (rst_pend & ~(done && done_src == SRC_RST));
    nmi_pend_nxt = nmi_fall | (nmi_pend & ~(done && done_src == SRC_NMI));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_d    <= 1'b0;
      nmi_d    <= 1'b1;
      rst_pend <= 1'b1;
      nmi_pend <= 1'b0;
    end else begin
      rst_d    <= rst_req;
      nmi_d    <= nmi_n;
      rst_pend <= rst_pend_nxt;
      nmi_pend <= nmi_pend_nxt;
    end
  end
endmodule

// File: rtl/irq_seq_arb.sv
module irq_seq_arb
  import irq_seq_pkg::*;
(
  input  logic rst_pend,
  input  logic nmi_pend,
  input  logic irq_req,
  input  logic brk_req,
  input  logic i_mask,
  output logic req_any,
  output src_e req_src
);
  logic irq_ok;
  assign irq_ok  = irq_req & ~i_mask;
  assign req_any = rst_pend | nmi_pend | irq_ok | brk_req;

  always_comb begin
    if (rst_pend)      req_src = SRC_RST;
    else if (nmi_pend) req_src = SRC_NMI;
    else if (irq_ok)   req_src = SRC_IRQ;
    else               req_src = SRC_BRK;
  end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned STACK_PAGE = 'h01,
  parameter int unsigned I_BIT      = 2,
  parameter int unsigned B_BIT      = 4,
  parameter int unsigned VEC_NMI    = 'hFFFA,
  parameter int unsigned VEC_RST    = 'hFFFC,
  parameter int unsigned VEC_IRQ    = 'hFFFE,
  localparam int unsigned ADDR_W    = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boundary,
  input  logic              rst_req,
  input  logic              nmi_n,
  input  logic              irq_req,
  input  logic              brk_req,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [DATA_W-1:0] sp_in,
  input  logic [DATA_W-1:0] p_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              sp_we,
  output logic [DATA_W-1:0] sp_out,
  output logic              i_set,
  output logic              pc_we,
  output logic [ADDR_W-1:0] pc_out,
  output logic              busy
);
  localparam logic [DATA_W-1:0] PAGE = DATA_W'(STACK_PAGE);
  localparam logic [ADDR_W-1:0] V_NMI = ADDR_W'(VEC_NMI);
  localparam logic [ADDR_W-1:0] V_RST = ADDR_W'(VEC_RST);
  localparam logic [ADDR_W-1:0] V_IRQ = ADDR_W'(VEC_IRQ);

  seq_state_e        st_q, st_nxt;
  src_e              src_q, src_nxt, arb_src;
  logic [ADDR_W-1:0] ret_q, ret_nxt;
  logic [DATA_W-1:0] sp_q, sp_nxt, psr_q, psr_nxt, lo_q, lo_nxt, psr_push;
  logic [ADDR_W-1:0] vec_base;
  logic              rst_pend, nmi_pend, arb_any, start, seq_en, pushing;

  irq_seq_pending u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .rst_req  (rst_req),
    .nmi_n    (nmi_n),
    .done     (pc_we),
    .done_src (src_q),
    .rst_pend (rst_pend),
    .nmi_pend (nmi_pend)
  );

  irq_seq_arb u_arb (
    .rst_pend (rst_pend),
    .nmi_pend (nmi_pend),
    .irq_req  (irq_req),
    .brk_req  (brk_req),
    .i_mask   (p_in[I_BIT]),
    .req_any  (arb_any),
    .req_src  (arb_src)
  );

  assign start  = (st_q == ST_IDLE) & boundary & arb_any;
  assign seq_en = (st_q != ST_IDLE) | start;

  // next-state process
  always_comb begin
    st_nxt  = st_q;
    src_nxt = src_q;
    ret_nxt = ret_q;
    sp_nxt  = sp_q;
    psr_nxt = psr_q;
    lo_nxt  = lo_q;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          src_nxt = arb_src;
          ret_nxt = pc_in;
          sp_nxt  = sp_in;
          psr_nxt = p_in;
          st_nxt  = (arb_src == SRC_RST) ? ST_VEC_LO : ST_PSH_HI;
        end
      end
      ST_PSH_HI: begin
        sp_nxt = sp_q - 1'b1;
        st_nxt = ST_PSH_LO;
      end
      ST_PSH_LO: begin
        sp_nxt = sp_q - 1'b1;
        st_nxt = ST_PSH_ST;
      end
      ST_PSH_ST: begin
        sp_nxt = sp_q - 1'b1;
        st_nxt = ST_VEC_LO;
      end
      ST_VEC_LO: begin
        lo_nxt = mem_rdata;
        st_nxt = ST_VEC_HI;
      end
      ST_VEC_HI: st_nxt = ST_IDLE;
      default:   st_nxt = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      src_q <= SRC_RST;
      ret_q <= '0;
      sp_q  <= '0;
      psr_q <= '0;
      lo_q  <= '0;
    end else if (seq_en) begin
      st_q  <= st_nxt;
      src_q <= src_nxt;
      ret_q <= ret_nxt;
      sp_q  <= sp_nxt;
      psr_q <= psr_nxt;
      lo_q  <= lo_nxt;
    end
  end

  // outputs
  always_comb begin
    unique case (src_q)
      SRC_RST: vec_base = V_RST;
      SRC_NMI: vec_base = V_NMI;
      default: vec_base = V_IRQ;
    endcase
  end

  always_comb begin
    psr_push        = psr_q;
    psr_push[B_BIT] = (src_q == SRC_BRK);
  end

  assign pushing = (st_q == ST_PSH_HI) | (st_q == ST_PSH_LO) | (st_q == ST_PSH_ST);

  always_comb begin
    unique case (st_q)
      ST_PSH_HI: mem_wdata = ret_q[ADDR_W-1:DATA_W];
      ST_PSH_LO: mem_wdata = ret_q[DATA_W-1:0];
      ST_PSH_ST: mem_wdata = psr_push;
      default:   mem_wdata = '0;
    endcase
  end

  assign mem_addr = pushing ? {PAGE, sp_q}
                            : (vec_base | ADDR_W'(st_q == ST_VEC_HI));
  assign mem_we   = pushing;
  assign sp_we    = pushing;
  assign sp_out   = sp_q - 1'b1;
  assign i_set    = (st_q == ST_PSH_ST) | ((st_q == ST_VEC_LO) & (src_q == SRC_RST));
  assign pc_we    = (st_q == ST_VEC_HI);
  assign pc_out   = {mem_rdata, lo_q};
  assign busy     = (st_q != ST_IDLE);
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        boundary,
  input logic        busy,
  input logic        mem_we,
  input logic [15:0] mem_addr,
  input logic        sp_we,
  input logic [7:0]  sp_out,
  input logic        i_set,
  input logic        pc_we
);
  a_r1_start_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(boundary));

  a_r5_push_in_page_one: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_addr[15:8] == 8'h01);

  a_r5_sp_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_we && $past(sp_we)) |-> sp_out == $past(sp_out) - 8'd1);

  a_r11_effects_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || pc_we || i_set) |-> busy);

  a_r7_load_from_odd_vector: assert property (@(posedge clk) disable iff (!rst_n)
    pc_we |-> (!mem_we && mem_addr[0] && mem_addr[15:3] == 13'h1FFF));

  a_r11_end_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(pc_we));
endmodule

bind irq_entry_seq irq_entry_seq_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .boundary (boundary),
  .busy     (busy),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .sp_we    (sp_we),
  .sp_out   (sp_out),
  .i_set    (i_set),
  .pc_we    (pc_we)
);

// File: tb/sim_irq_entry_seq.sv
module sim_irq_entry_seq;
  logic clk = 1'b0;
  logic rst_n, boundary, rst_req, nmi_n, irq_req, brk_req;
  logic [15:0] pc_in;
  logic [7:0]  sp_in, p_in;
  logic [15:0] mem_addr, pc_out;
  logic        mem_we, sp_we, i_set, pc_we, busy;
  logic [7:0]  mem_wdata, mem_rdata, sp_out;

  always #4 clk = ~clk;

  irq_entry_seq u0 (
    .clk(clk), .rst_n(rst_n), .boundary(boundary), .rst_req(rst_req),
    .nmi_n(nmi_n), .irq_req(irq_req), .brk_req(brk_req),
    .pc_in(pc_in), .sp_in(sp_in), .p_in(p_in),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .sp_we(sp_we), .sp_out(sp_out),
    .i_set(i_set), .pc_we(pc_we), .pc_out(pc_out), .busy(busy)
  );

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    case (a)
      16'hFFFA: return 8'h11;
      16'hFFFB: return 8'h22;
      16'hFFFC: return 8'h33;
      16'hFFFD: return 8'h44;
      16'hFFFE: return 8'h55;
      16'hFFFF: return 8'h66;
      default:  return 8'h00;
    endcase
  endfunction

  assign mem_rdata = mem_byte(mem_addr);

  typedef struct {
    logic        busy, we, chk_addr, spwe, iset, pcwe;
    logic [15:0] addr, pc;
    logic [7:0]  wd, spo;
    string       tag;
  } exp_t;

  exp_t exq[$];
  int checks = 0, fails = 0;
  bit finished = 0;

  function automatic exp_t idle_exp();
    exp_t e;
    e.busy = 0; e.we = 0; e.chk_addr = 0; e.spwe = 0; e.iset = 0; e.pcwe = 0;
    e.addr = '0; e.pc = '0; e.wd = '0; e.spo = '0; e.tag = "R1/R11 idle";
    return e;
  endfunction

  function automatic exp_t push_exp(input logic [15:0] a, input logic [7:0] d,
                                    input logic [7:0] s, input logic is, input string t);
    exp_t e = idle_exp();
    e.busy = 1; e.we = 1; e.chk_addr = 1; e.addr = a; e.wd = d;
    e.spwe = 1; e.spo = s; e.iset = is; e.tag = t;
    return e;
  endfunction

  function automatic exp_t read_exp(input logic [15:0] a, input logic is,
                                    input logic pw, input logic [15:0] pcv, input string t);
    exp_t e = idle_exp();
    e.busy = 1; e.chk_addr = 1; e.addr = a; e.iset = is; e.pcwe = pw; e.pc = pcv; e.tag = t;
    return e;
  endfunction

  // kind: 0 non-maskable, 1 maskable, 2 break
  task automatic exp_entry(input int kind, input logic [15:0] pc,
                           input logic [7:0] sp, input logic [7:0] p);
    logic [15:0] v;
    logic [7:0]  st;
    v  = (kind == 0) ? 16'hFFFA : 16'hFFFE;
    st = (p & 8'hEF) | ((kind == 2) ? 8'h10 : 8'h00);
    exq.push_back(push_exp({8'h01, sp}, pc[15:8], sp - 8'd1, 0, "R5 push high"));
    exq.push_back(push_exp({8'h01, 8'(sp - 8'd1)}, pc[7:0], sp - 8'd2, 0, "R5 push low"));
    exq.push_back(push_exp({8'h01, 8'(sp - 8'd2)}, st, sp - 8'd3, 1, "R6 push status"));
    exq.push_back(read_exp(v, 0, 0, '0, "R7 vector low"));
    exq.push_back(read_exp(v | 16'h1, 0, 1, {mem_byte(v | 16'h1), mem_byte(v)}, "R7 vector high"));
  endtask

  task automatic exp_reset();
    exq.push_back(read_exp(16'hFFFC, 1, 0, '0, "R3 reset low"));
    exq.push_back(read_exp(16'hFFFD, 0, 1, 16'h4433, "R3 reset high"));
  endtask

  // monitor: one compare per cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !finished) begin
      exp_t e;
      bit bad;
      e = (exq.size() > 0) ? exq.pop_front() : idle_exp();
      bad = (busy !== e.busy) || (mem_we !== e.we) || (sp_we !== e.spwe) ||
            (i_set !== e.iset) || (pc_we !== e.pcwe);
      if (e.chk_addr && mem_addr !== e.addr) bad = 1;
      if (e.we && mem_wdata !== e.wd) bad = 1;
      if (e.spwe && sp_out !== e.spo) bad = 1;
      if (e.pcwe && pc_out !== e.pc) bad = 1;
      checks++;
      if (bad) begin
        fails++;
        $display("FAIL %s: actual busy=%b we=%b addr=%h wd=%h spwe=%b sp=%h iset=%b pcwe=%b pc=%h expected busy=%b we=%b addr=%h wd=%h spwe=%b sp=%h iset=%b pcwe=%b pc=%h",
                 e.tag, busy, mem_we, mem_addr, mem_wdata, sp_we, sp_out, i_set, pc_we, pc_out,
                 e.busy, e.we, e.addr, e.wd, e.spwe, e.spo, e.iset, e.pcwe, e.pc);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // boundary is already high; register expectations for the cycle after the edge
  task automatic take_reset();
    boundary = 1;
    @(negedge clk); #1;
    exp_reset();
    @(posedge clk); #1;
    boundary = 0;
  endtask

  task automatic take_entry(input int kind);
    boundary = 1;
    @(negedge clk); #1;
    exp_entry(kind, pc_in, sp_in, p_in);
    @(posedge clk); #1;
    boundary = 0;
  endtask

  task automatic pulse_boundary_idle();
    boundary = 1;
    cyc(1);
    boundary = 0;
  endtask

  task automatic finish_run();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    rst_n = 0; boundary = 0; rst_req = 0; nmi_n = 1; irq_req = 0; brk_req = 0;
    pc_in = 16'h1234; sp_in = 8'h01; p_in = 8'h20;
    cyc(3);
    // reset state: idle with no activity (R10: pending but needs a boundary, R1)
    checks++;
    if (busy !== 0 || mem_we !== 0 || pc_we !== 0) begin
      fails++;
      $display("FAIL R11 reset state: actual busy=%b we=%b pcwe=%b expected 0 0 0", busy, mem_we, pc_we);
    end
    rst_n = 1;
    cyc(3);
    // R10 / R3: reset entry at first boundary
    take_reset();
    cyc(3);
    // R4 / R5: maskable entry, SP wraps from 0x01 down through 0xFF
    irq_req = 1;
    take_entry(1);
    irq_req = 0;
    cyc(6);
    // R4: masked request dropped, nothing pending afterwards
    p_in = 8'h24; irq_req = 1;
    pulse_boundary_idle();
    cyc(2);
    p_in = 8'h20; irq_req = 0;
    pulse_boundary_idle();
    cyc(2);
    // R1: request without boundary does nothing
    irq_req = 1;
    cyc(5);
    irq_req = 0;
    // R2 / R8: non-maskable beats maskable; pin held low gives one service
    pc_in = 16'hA5C3; sp_in = 8'hF0;
    nmi_n = 0;
    cyc(3);
    irq_req = 1;
    take_entry(0);
    cyc(6);
    take_entry(1);
    irq_req = 0;
    cyc(6);
    pulse_boundary_idle();   // R9: nothing left pending
    cyc(2);
    nmi_n = 1;
    cyc(2);
    // R6: break pushes bit 4 set, uses 0xFFFE
    pc_in = 16'h8002; sp_in = 8'hFF; p_in = 8'h21;
    brk_req = 1;
    take_entry(2);
    brk_req = 0;
    cyc(6);
    // R2 / R9: reset beats non-maskable; non-maskable then served once
    rst_req = 1; nmi_n = 0;
    cyc(1);
    rst_req = 0;
    cyc(2);
    take_reset();
    cyc(3);
    take_entry(0);
    cyc(6);
    pulse_boundary_idle();
    cyc(2);
    nmi_n = 1;
    cyc(2);
    // R8: edge during a maskable entry is served later
    irq_req = 1; pc_in = 16'h0F0F; sp_in = 8'h80; p_in = 8'h00;
    take_entry(1);
    irq_req = 0;
    nmi_n = 0;
    cyc(6);
    take_entry(0);
    cyc(6);
    pulse_boundary_idle();
    cyc(3);
    checks++;
    if (exq.size() != 0) begin
      fails++;
      $display("FAIL R11 leftover expectations: actual %0d expected 0", exq.size());
    end
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end
endmodule